// File: doc/BRIEF.md
# Cache Array Test-Access Port

This block gives software a small register window onto the storage arrays of an L1 data cache, for test, initialization and debug. A write to the command register starts exactly one access. That access either reads or writes one entry of the data array or of the tag array. The entry is picked by a way, a set and a word-within-line field. Data moves through two 32-bit data registers, which together carry one 64-bit data word. A tag entry uses only the low data register.

The valid bits are held in flops that sit apart from the tag RAM. This lets a single tag write mark any one line invalid. It also lets software invalidate every line at once by writing zero to the cache-mode field of the control register. Writing the old mode back later restores the configuration, and every line stays invalid. The data and tag arrays are plain internal RAMs. Normal lookup and refill are not part of this block.

The register map uses offset 0 for command, 1 for the low data register, 2 for the high data register and 3 for control. Reads through `bus_rdata` are combinational.

Top module: `cprobe_top`

## Requirements
- R1: A data-array write stores {data register 2, data register 1} as one 64-bit word at the selected way, set and word. A later data-array read of that entry loads the low 32 bits into register 1 and the high 32 bits into register 2.
- R2: A tag read loads register 1 with the tag in bits [31:12], the dirty bit in bit 1, the valid bit in bit 0 and zeros in bits [11:2]. Register 2 keeps its value.
- R3: A tag write takes tag, dirty and valid from register 1 in the R2 layout. Writing valid=0 invalidates that one line and no other line.
- R4: An access starts only on a write to offset 0 with bit 0 set. Bit 1 selects write (1) or read (0), bit 2 selects the data array (1) or the tag array (0), bits [8+] hold the way, bits [16+] the set and bits [24+] the word. Writes to other offsets, and command writes with bit 0 clear, start nothing.
- R5: Bit 31 of the command register reads 1 for the two cycles after the clock edge that takes a starting command. It reads 0 from the second edge after that one on, and read results are in the data registers at that point.
- R6: Writing the control register with mode field bits [1:0] equal to 00 clears the valid bit of every line in one cycle. It keeps tag, dirty and data contents.
- R7: A later control write with a nonzero mode reads back that mode, and every line stays invalid.
- R8: A command write while an access is in flight is ignored. It neither starts an access nor changes the command readback.
- R9: After reset, all registers read 0, no access is in flight and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench builds the block with 2 ways, 8 sets and 2 words per line. This makes the arrays small enough to sweep completely: 32 data entries and 16 tag entries. Every data entry is written with a pattern computed from its own address and then read back. This shows that the way, set and word fields each reach their own entry. Every tag line is checked again after the bulk invalidate, so the bench sees that only the valid bits were cleared and that the tags and dirty bits were kept.

// File: rtl/cprobe_pkg.sv
package cprobe_pkg;
   localparam logic [1:0] A_CMD  = 2'd0;
   localparam logic [1:0] A_DLO  = 2'd1;
   localparam logic [1:0] A_DHI  = 2'd2;
   localparam logic [1:0] A_CTRL = 2'd3;

   localparam int B_GO   = 0;
   localparam int B_WR   = 1;
   localparam int B_DAT  = 2;
   localparam int WAY_LSB  = 8;
   localparam int SET_LSB  = 16;
   localparam int WORD_LSB = 24;

   typedef enum logic [1:0] {PH_IDLE, PH_ACCESS, PH_LOAD} phase_t;
endpackage

// File: rtl/cprobe_ram.sv
module cprobe_ram #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [W-1:0]             wdata,
   output logic [W-1:0]             rdata
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cprobe_ram: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/cprobe_valid.sv
module cprobe_valid #(
   parameter int LINES = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     we,
   input  logic [$clog2(LINES)-1:0] widx,
   input  logic                     wval,
   output logic [LINES-1:0]         bits
);
   localparam int IW = $clog2(LINES);

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       bits[i] <= 1'b0;
            else if (clr)                     bits[i] <= 1'b0;
            else if (we && widx == IW'(i))    bits[i] <= wval;
         end
      end
   endgenerate

   // R6: bulk clear empties every valid bit on the next cycle
   p_bulk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> bits == '0);
   // R3: a single tag write touches at most one line
   p_single_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> $countones(bits ^ $past(bits)) <= 1);
   // R3: with no write and no clear the valid bits hold
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !clr) |=> $stable(bits));
endmodule

// File: rtl/cprobe_top.sv
module cprobe_top
   import cprobe_pkg::*;
#(
   parameter int WAYS  = 2,
   parameter int SETS  = 64,
   parameter int WORDS = 4,
   parameter int TAG_W = 20,
   parameter int BUS_W = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata
);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int SET_W  = $clog2(SETS);
   localparam int WORD_W = $clog2(WORDS);
   localparam int LINES  = WAYS * SETS;
   localparam int LINE_W = WAY_W + SET_W;
   localparam int DENT   = LINES * WORDS;
   localparam int DIDX_W = LINE_W + WORD_W;
   localparam int PAD_W  = BUS_W - TAG_W - 2;

   generate
      if (BUS_W != 32) begin : g_bad_bus
         $error("cprobe_top: BUS_W must be 32");
      end
      if (WAYS < 2 || SETS < 2 || WORDS < 2) begin : g_bad_geom
         $error("cprobe_top: WAYS, SETS and WORDS must each be at least 2");
      end
      if (WAY_W > 8 || SET_W > 8 || WORD_W > 7) begin : g_bad_fields
         $error("cprobe_top: index field too wide for command layout");
      end
      if (PAD_W < 1) begin : g_bad_tag
         $error("cprobe_top: TAG_W leaves no room for dirty and valid");
      end
   endgenerate

   // bus decode
   logic wr_cmd, wr_dlo, wr_dhi, wr_ctrl;
   assign wr_cmd  = bus_wr && bus_addr == A_CMD;
   assign wr_dlo  = bus_wr && bus_addr == A_DLO;
   assign wr_dhi  = bus_wr && bus_addr == A_DHI;
   assign wr_ctrl = bus_wr && bus_addr == A_CTRL;

   phase_t phase;
   logic   start;
   assign start = wr_cmd && bus_wdata[B_GO] && phase == PH_IDLE;

   // captured command
   logic              c_wr, c_dat;
   logic [WAY_W-1:0]  c_way;
   logic [SET_W-1:0]  c_set;
   logic [WORD_W-1:0] c_word;
   logic [2*BUS_W-1:0] c_wdata;
   logic [BUS_W-2:0]  cmd_reg;
   logic [BUS_W-1:0]  dlo, dhi;
   logic [1:0]        mode;
   logic              v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         c_wr    <= 1'b0;
         c_dat   <= 1'b0;
         c_way   <= '0;
         c_set   <= '0;
         c_word  <= '0;
         c_wdata <= '0;
         cmd_reg <= '0;
      end else begin
         if (wr_cmd && phase == PH_IDLE) cmd_reg <= bus_wdata[BUS_W-2:0];
         unique case (phase)
            PH_IDLE: if (start) begin
               phase   <= PH_ACCESS;
               c_wr    <= bus_wdata[B_WR];
               c_dat   <= bus_wdata[B_DAT];
               c_way   <= bus_wdata[WAY_LSB  +: WAY_W];
               c_set   <= bus_wdata[SET_LSB  +: SET_W];
               c_word  <= bus_wdata[WORD_LSB +: WORD_W];
               c_wdata <= {dhi, dlo};
            end
            PH_ACCESS: phase <= PH_LOAD;
            PH_LOAD:   phase <= PH_IDLE;
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   // array ports
   logic [LINE_W-1:0]  line_idx;
   logic [DIDX_W-1:0]  data_idx;
   logic               acc, tag_we, dat_we;
   logic [2*BUS_W-1:0] dat_rd;
   logic [TAG_W:0]     tag_rd;
   logic [LINES-1:0]   vbits;
   logic               bulk_clr;

   assign line_idx = {c_way, c_set};
   assign data_idx = {c_way, c_set, c_word};
   assign acc      = phase == PH_ACCESS;
   assign tag_we   = acc && c_wr && !c_dat;
   assign dat_we   = acc && c_wr && c_dat;
   assign bulk_clr = wr_ctrl && bus_wdata[1:0] == 2'b00;

   cprobe_ram #(.W(2*BUS_W), .DEPTH(DENT)) u_data (
      .clk(clk), .we(dat_we), .addr(data_idx), .wdata(c_wdata), .rdata(dat_rd));

   cprobe_ram #(.W(TAG_W+1), .DEPTH(LINES)) u_tag (
      .clk(clk), .we(tag_we), .addr(line_idx),
      .wdata({c_wdata[BUS_W-1 -: TAG_W], c_wdata[1]}), .rdata(tag_rd));

   cprobe_valid #(.LINES(LINES)) u_valid (
      .clk(clk), .rst_n(rst_n), .clr(bulk_clr), .we(tag_we),
      .widx(line_idx), .wval(c_wdata[0]), .bits(vbits));

   logic [BUS_W-1:0] tag_word;
   assign tag_word = {tag_rd[TAG_W:1], {PAD_W{1'b0}}, tag_rd[0], v_q};

   // data registers, control and valid sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dlo  <= '0;
         dhi  <= '0;
         mode <= 2'b00;
         v_q  <= 1'b0;
      end else begin
         if (acc) v_q <= vbits[line_idx];
         if (wr_ctrl) mode <= bus_wdata[1:0];
         if (phase == PH_LOAD && !c_wr) begin
            if (c_dat) begin
               dlo <= dat_rd[BUS_W-1:0];
               dhi <= dat_rd[2*BUS_W-1:BUS_W];
            end else begin
               dlo <= tag_word;
               if (wr_dhi) dhi <= bus_wdata;
            end
         end else begin
            if (wr_dlo) dlo <= bus_wdata;
            if (wr_dhi) dhi <= bus_wdata;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CMD:   bus_rdata = {phase != PH_IDLE, cmd_reg};
         A_DLO:   bus_rdata = dlo;
         A_DHI:   bus_rdata = dhi;
         default: bus_rdata = {30'd0, mode};
      endcase
   end

   // R5: access takes a fixed two cycles
   p_access_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_ACCESS |=> phase == PH_LOAD);
   p_load_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_LOAD |=> phase == PH_IDLE);
   // R4: nothing starts without a command write carrying the enable bit
   p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !(wr_cmd && bus_wdata[B_GO])) |=> phase == PH_IDLE);
   // R8: command readback frozen while busy
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      phase != PH_IDLE |=> $stable(cmd_reg));
   // R2: tag read leaves the high data register alone
   p_tag_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOAD && !c_wr && !c_dat && !wr_dhi) |=> $stable(dhi));
endmodule

// File: tb/sim_cprobe_top.sv
module sim_cprobe_top;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 2, NS = 8, NWD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cprobe_top #(.WAYS(NW), .SETS(NS), .WORDS(NWD), .TAG_W(20), .BUS_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] mk(input bit go, input bit w, input bit dat,
                                      input int way, input int set, input int word);
      return 32'(go) | (32'(w) << 1) | (32'(dat) << 2) |
             (32'(way) << 8) | (32'(set) << 16) | (32'(word) << 24);
   endfunction

   task automatic cmd(input logic [31:0] c);
      wr(2'd0, c);
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] dpat(input int w, input int s, input int k);
      return 32'hA500_0000 | 32'((w << 12) | (s << 4) | k);
   endfunction

   function automatic logic [19:0] tpat(input int w, input int s);
      return 20'((w * NS + s) * 32'h1357 + 5);
   endfunction

   function automatic logic [31:0] tword(input int w, input int s, input bit v);
      return {tpat(w, s), 10'd0, 1'(s & 1), v};
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      rd(2'd0, a); check("R9 cmd", 64'(a), 64'd0);
      rd(2'd1, a); check("R9 dlo", 64'(a), 64'd0);
      rd(2'd2, a); check("R9 dhi", 64'(a), 64'd0);
      rd(2'd3, a); check("R9 ctrl", 64'(a), 64'd0);
      cmd(mk(1, 0, 0, 1, 5, 0));
      rd(2'd1, a); check("R9 line invalid", 64'(a[0]), 64'd0);
      wr(2'd3, 32'd3);

      // R1 data sweep write
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++)
            for (int k = 0; k < NWD; k++) begin
               wr(2'd1, dpat(w, s, k));
               wr(2'd2, ~dpat(w, s, k));
               cmd(mk(1, 1, 1, w, s, k));
            end
      // R1 and R9 data read back
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++)
            for (int k = 0; k < NWD; k++) begin
               cmd(mk(1, 0, 1, w, s, k));
               rd(2'd1, a); rd(2'd2, b);
               check("R1 data entry", {b, a}, {~dpat(w, s, k), dpat(w, s, k)});
            end

      // R5 busy timing
      wr(2'd0, mk(1, 0, 1, 0, 2, 1));
      rd(2'd0, a); check("R5 busy first", 64'(a[31]), 64'd1);
      @(negedge clk);
      rd(2'd0, a); check("R5 busy second", 64'(a[31]), 64'd1);
      @(negedge clk);
      rd(2'd0, a); check("R5 idle", 64'(a[31]), 64'd0);
      rd(2'd1, a); check("R5 data ready", 64'(a), 64'(dpat(0, 2, 1)));

      // R8 command while busy
      wr(2'd0, mk(1, 0, 1, 1, 6, 0));
      wr(2'd0, mk(1, 0, 1, 0, 3, 1));
      @(negedge clk);
      rd(2'd1, a); check("R8 first access wins", 64'(a), 64'(dpat(1, 6, 0)));
      rd(2'd0, a); check("R8 readback", 64'(a), 64'(mk(1, 0, 1, 1, 6, 0)));
      @(negedge clk); @(negedge clk);
      rd(2'd1, a); check("R8 no second access", 64'(a), 64'(dpat(1, 6, 0)));

      // R4 enable clear and other writes start nothing
      wr(2'd1, 32'h1234_5678);
      wr(2'd0, mk(0, 0, 1, 0, 0, 0));
      rd(2'd0, a); check("R4 no busy", 64'(a[31]), 64'd0);
      @(negedge clk); @(negedge clk);
      rd(2'd1, a); check("R4 dlo kept", 64'(a), 64'h1234_5678);
      wr(2'd2, 32'h0000_0001);
      rd(2'd0, a); check("R4 data write no busy", 64'(a[31]), 64'd0);

      // R3 tag sweep write
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++) begin
            wr(2'd1, tword(w, s, 1));
            cmd(mk(1, 1, 0, w, s, 0));
         end
      wr(2'd2, 32'hDEAD_BEEF);
      // R2 tag read back
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++) begin
            cmd(mk(1, 0, 0, w, s, 0));
            rd(2'd1, a);
            check("R2 tag entry", 64'(a), 64'(tword(w, s, 1)));
         end
      rd(2'd2, a); check("R2 dhi unchanged", 64'(a), 64'hDEAD_BEEF);

      // R3 single line invalidate
      wr(2'd1, tword(1, 3, 0));
      cmd(mk(1, 1, 0, 1, 3, 0));
      cmd(mk(1, 0, 0, 1, 3, 0));
      rd(2'd1, a); check("R3 target invalid", 64'(a), 64'(tword(1, 3, 0)));
      cmd(mk(1, 0, 0, 0, 3, 0));
      rd(2'd1, a); check("R3 neighbour way", 64'(a), 64'(tword(0, 3, 1)));
      cmd(mk(1, 0, 0, 1, 4, 0));
      rd(2'd1, a); check("R3 neighbour set", 64'(a), 64'(tword(1, 4, 1)));

      // R6 bulk invalidate, R7 restore
      wr(2'd3, 32'd0);
      rd(2'd3, a); check("R6 mode cleared", 64'(a), 64'd0);
      wr(2'd3, 32'd2);
      rd(2'd3, a); check("R7 mode restored", 64'(a), 64'd2);
      for (int w = 0; w < NW; w++)
         for (int s = 0; s < NS; s++) begin
            cmd(mk(1, 0, 0, w, s, 0));
            rd(2'd1, a);
            check("R6 R7 line invalid tag kept", 64'(a), 64'(tword(w, s, 0)));
         end
      cmd(mk(1, 0, 1, 1, 7, 1));
      rd(2'd1, a); rd(2'd2, b);
      check("R6 data kept", {b, a}, {~dpat(1, 7, 1), dpat(1, 7, 1)});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule